// File: doc/BRIEF.md
# Coder Host Control and Interrupt Unit

This block sits between a host processor and a bilevel image arithmetic coding engine. Over a small synchronous byte bus the host sets up three things: the interrupt enables together with a halt-on-marker control bit, the pixel count per line, and the number of lines a job must process. The block also holds a read-only status byte. Single-cycle event strobes from the engine set sticky status bits. Each status bit is masked by its enable, and the results are ORed into one interrupt request.

A start command clears a line counter and opens a job. Each line-done strobe then advances the counter until it reaches the programmed target. At that point the job closes, a one-cycle target-reached pulse is issued and the job-stop status is set. During decoding, a detected marker can freeze the job until the host clears the halt bit. While a job runs, the line target can be rewritten only through a maximum-first protocol, so the engine never sees an unsafe change.

Top module: `coder_host_ctrl`

## Requirements
- R1: After reset, intr_o and halt_o are 0, the status (address 2), enable (address 3) and pixel (addresses 4, 5) bytes read 0x00, and the line target (addresses 6, 7) reads 0xFF, 0xFF.
- R2: Address 3 holds four enable bits in bits 3..0 and the halt-on-marker bit in bit 7. Bits 6..4 always read 0.
- R3: The pixel count is 14 bits. Its low byte is at address 4 and its upper six bits are at address 5 bits 5..0. Bits 7..6 of address 5 read 0. rdata_o is valid in the cycle after rd_i, and the 14-bit value changes only when address 5 is written.
- R4: The line target has its low byte at address 6 and its high byte at address 7. A write to address 6 alone changes nothing that can be read. The target is updated on the address 7 write, and an update to the value 0 is discarded.
- R5: The status byte at address 2 uses bit 0 for job stop, bit 1 for data ready, bit 2 for marker and bit 4 for SC overflow. Bits 3 and 7..5 read 0. A set bit stays set until reset, whatever the host reads or writes to the enables.
- R6: intr_o is 1 exactly when some status bit is set and its enable is set. Enable bits 0, 1 and 2 gate status bits 0, 1 and 2, and enable bit 3 gates status bit 4. Clearing an enable removes that cause at once.
- R7: A job-stop event raises intr_o even while the job is halted on a marker.
- R8: A marker strobe during a decode job with the halt bit at 1 sets halt_o from the next cycle. While halted, line-done strobes are not counted. Writing the halt bit to 0 drops halt_o, and counting then resumes toward the target.
- R9: A marker strobe sets no halt when the job is coding (decode_i is 0) or when the halt bit is 0.
- R10: An SC overflow strobe during a coding job sets status bit 4, and the job keeps counting lines.
- R11: start_i clears the line counter and opens a job. When the count reaches the target, target_hit_o pulses for one cycle, status bit 0 is set and the job closes, so further line-done strobes produce no pulse.
- R12: While a job runs, a target update is accepted in two cases: it is the value 0xFFFF, or it is the first update after the job started with a target of 0xFFFF or after an accepted 0xFFFF update. Any other update is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid in the cycle after rd_i |
| start_i | input | 1 | Process start command |
| decode_i | input | 1 | 1 = decoding job, 0 = coding job |
| stop_evt_i | input | 1 | Engine job stop or trailer end strobe |
| rdy_evt_i | input | 1 | Engine data transfer ready strobe |
| marker_evt_i | input | 1 | Marker code detected strobe |
| ovf_evt_i | input | 1 | SC counter overflow strobe |
| line_done_i | input | 1 | One line processed strobe |
| pel_o | output | 14 | Committed pixels per line |
| target_o | output | 16 | Committed line target |
| intr_o | output | 1 | Interrupt request |
| halt_o | output | 1 | Halt request to the engine |
| target_hit_o | output | 1 | One-cycle pulse when the line target is reached |

## Verification
The bench targets the rewrite protocol for the line target. A design that accepted any write mid-job would move the target, and one that lost the one-shot allowance after a 0xFFFF start would freeze it. Both show up in readback and in the cycle where the hit pulse occurs. Line-done strobes are issued while the job is halted: a counter that kept running would pulse early. The check that status survives an enable being cleared catches a design that wipes status on a mask write, and the enable-3 to status-4 mapping catches an off-by-one in the gating.

// File: rtl/chc_pkg.sv
package chc_pkg;
  localparam int DW = 8;
  localparam int AW = 3;

  localparam logic [AW-1:0] A_STAT  = 3'd2;
  localparam logic [AW-1:0] A_IEN   = 3'd3;
  localparam logic [AW-1:0] A_PEL_L = 3'd4;
  localparam logic [AW-1:0] A_PEL_H = 3'd5;
  localparam logic [AW-1:0] A_LIN_L = 3'd6;
  localparam logic [AW-1:0] A_LIN_H = 3'd7;

  localparam int ST_W    = 5;
  localparam int ST_STOP = 0;
  localparam int ST_RDY  = 1;
  localparam int ST_MRK  = 2;
  localparam int ST_OVF  = 4;
  localparam int IEN_W   = 4;
endpackage

// File: rtl/chc_regs.sv
module chc_regs
  import chc_pkg::*;
#(
  parameter int PEL_W  = 14,
  parameter int LINE_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic              wr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              start_i,
  input  logic              active_i,
  output logic [IEN_W-1:0]  ien_o,
  output logic              mp_o,
  output logic [PEL_W-1:0]  pel_o,
  output logic [LINE_W-1:0] target_o
);
  localparam int PH_W = PEL_W - DW;
  localparam int LH_W = LINE_W - DW;
  localparam logic [LINE_W-1:0] LMAX = '1;

  logic [IEN_W-1:0]  ien_q;
  logic              mp_q;
  logic [DW-1:0]     pel_lo_q;
  logic [PEL_W-1:0]  pel_q;
  logic [DW-1:0]     lin_lo_q;
  logic [LINE_W-1:0] target_q;
  logic              rearm_q;

  logic [LINE_W-1:0] cand;
  logic              lin_wr, cand_max, cand_ok;

  assign cand     = {wdata_i[LH_W-1:0], lin_lo_q};
  assign lin_wr   = wr_i && (addr_i == A_LIN_H);
  assign cand_max = (cand == LMAX);
  // zero is never a legal target; mid-job only max or a re-armed rewrite
  assign cand_ok  = (cand != '0) && (!active_i || cand_max || rearm_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_q    <= '0;
      mp_q     <= 1'b0;
      pel_lo_q <= '0;
      pel_q    <= '0;
      lin_lo_q <= '0;
      target_q <= LMAX;
      rearm_q  <= 1'b0;
    end else begin
      if (wr_i && addr_i == A_IEN) begin
        ien_q <= wdata_i[IEN_W-1:0];
        mp_q  <= wdata_i[DW-1];
      end
      if (wr_i && addr_i == A_PEL_L) pel_lo_q <= wdata_i;
      if (wr_i && addr_i == A_PEL_H) pel_q <= {wdata_i[PH_W-1:0], pel_lo_q};
      if (wr_i && addr_i == A_LIN_L) lin_lo_q <= wdata_i;
      if (start_i) begin
        rearm_q <= (target_q == LMAX);
      end else if (lin_wr && cand_ok) begin
        target_q <= cand;
        if (active_i) rearm_q <= cand_max;
      end
    end
  end

  assign ien_o    = ien_q;
  assign mp_o     = mp_q;
  assign pel_o    = pel_q;
  assign target_o = target_q;

  // R12
  target_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lin_wr && active_i && !start_i && !rearm_q && !cand_max) |=> $stable(target_q));
  // R4
  target_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    target_q != '0);
endmodule

// File: rtl/chc_status.sv
module chc_status
  import chc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stop_i,
  input  logic             rdy_i,
  input  logic             mrk_i,
  input  logic             ovf_i,
  input  logic [IEN_W-1:0] ien_i,
  output logic [ST_W-1:0]  status_o,
  output logic             intr_o
);
  logic [ST_W-1:0] st_q;
  logic [ST_W-1:0] st_set;

  always_comb begin
    st_set          = '0;
    st_set[ST_STOP] = stop_i;
    st_set[ST_RDY]  = rdy_i;
    st_set[ST_MRK]  = mrk_i;
    st_set[ST_OVF]  = ovf_i;
  end

  // sticky: only reset clears
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= st_q | st_set;
  end

  assign status_o = st_q;
  assign intr_o   = |({st_q[ST_OVF], st_q[ST_MRK], st_q[ST_RDY], st_q[ST_STOP]} & ien_i);

  // R5
  status_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q & $past(st_q)) == $past(st_q));
  // R6
  intr_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien_i == '0) |-> !intr_o);
endmodule

// File: rtl/chc_job.sv
module chc_job #(
  parameter int LINE_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              decode_i,
  input  logic              mp_i,
  input  logic              marker_i,
  input  logic              line_done_i,
  input  logic [LINE_W-1:0] target_i,
  output logic              active_o,
  output logic              halt_o,
  output logic              hit_o
);
  logic              active_q, paused_q, hit_q;
  logic [LINE_W-1:0] cnt_q;
  logic [LINE_W-1:0] cnt_nxt;
  logic              line_ok, done;

  assign halt_o  = paused_q && mp_i;
  assign line_ok = line_done_i && active_q && !halt_o;
  assign cnt_nxt = cnt_q + 1'b1;
  // >= covers a target lowered below the running count
  assign done    = line_ok && (cnt_nxt >= target_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      paused_q <= 1'b0;
      hit_q    <= 1'b0;
      cnt_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      paused_q <= 1'b0;
      hit_q    <= 1'b0;
      cnt_q    <= '0;
    end else begin
      hit_q <= done;
      if (line_ok) cnt_q <= cnt_nxt;
      if (done) active_q <= 1'b0;
      if (!mp_i) paused_q <= 1'b0;
      else if (marker_i && decode_i && active_q) paused_q <= 1'b1;
    end
  end

  assign active_o = active_q;
  assign hit_o    = hit_q;

  // R8
  halt_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halt_o) |-> $past(marker_i));
  // R8
  halt_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_o && !start_i) |=> $stable(cnt_q));
  // R11
  hit_ends_job_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> !active_o);
endmodule

// File: rtl/coder_host_ctrl.sv
module coder_host_ctrl
  import chc_pkg::*;
#(
  parameter int PEL_W  = 14,
  parameter int LINE_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic              start_i,
  input  logic              decode_i,
  input  logic              stop_evt_i,
  input  logic              rdy_evt_i,
  input  logic              marker_evt_i,
  input  logic              ovf_evt_i,
  input  logic              line_done_i,
  output logic [PEL_W-1:0]  pel_o,
  output logic [LINE_W-1:0] target_o,
  output logic              intr_o,
  output logic              halt_o,
  output logic              target_hit_o
);
  localparam int PH_W = PEL_W - DW;

  logic [IEN_W-1:0]  ien;
  logic              mp;
  logic [PEL_W-1:0]  pel;
  logic [LINE_W-1:0] target;
  logic              active, hit;
  logic [ST_W-1:0]   status;
  logic [DW-1:0]     rdata_q;

  chc_regs #(.PEL_W(PEL_W), .LINE_W(LINE_W)) u_regs (
    .clk_i, .rst_ni, .addr_i, .wr_i, .wdata_i, .start_i,
    .active_i(active), .ien_o(ien), .mp_o(mp), .pel_o(pel), .target_o(target)
  );

  chc_job #(.LINE_W(LINE_W)) u_job (
    .clk_i, .rst_ni, .start_i, .decode_i, .mp_i(mp), .marker_i(marker_evt_i),
    .line_done_i, .target_i(target), .active_o(active), .halt_o(halt_o), .hit_o(hit)
  );

  chc_status u_status (
    .clk_i, .rst_ni,
    .stop_i(stop_evt_i || hit),
    .rdy_i(rdy_evt_i),
    .mrk_i(marker_evt_i && decode_i && active),
    .ovf_i(ovf_evt_i && !decode_i && active),
    .ien_i(ien), .status_o(status), .intr_o(intr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (rd_i) begin
      unique case (addr_i)
        A_STAT:  rdata_q <= {{(DW-ST_W){1'b0}}, status};
        A_IEN:   rdata_q <= {mp, {(DW-1-IEN_W){1'b0}}, ien};
        A_PEL_L: rdata_q <= pel[DW-1:0];
        A_PEL_H: rdata_q <= {{(DW-PH_W){1'b0}}, pel[PEL_W-1:DW]};
        A_LIN_L: rdata_q <= target[DW-1:0];
        A_LIN_H: rdata_q <= target[LINE_W-1:DW];
        default: rdata_q <= '0;
      endcase
    end
  end

  assign rdata_o      = rdata_q;
  assign pel_o        = pel;
  assign target_o     = target;
  assign target_hit_o = hit;

  // R10
  ovf_no_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && ovf_evt_i && !decode_i && !line_done_i) |=> active);
  // R5
  status_pad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status[3]);
endmodule

// File: tb/sim_coder_host_ctrl.sv
module sim_coder_host_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        start = 1'b0, decode = 1'b0;
  logic        stop_e = 1'b0, rdy_e = 1'b0, mrk_e = 1'b0, ovf_e = 1'b0, line_e = 1'b0;
  logic [13:0] pel;
  logic [15:0] target;
  logic        intr, halt, hit;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  coder_host_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .start_i(start), .decode_i(decode),
    .stop_evt_i(stop_e), .rdy_evt_i(rdy_e), .marker_evt_i(mrk_e),
    .ovf_evt_i(ovf_e), .line_done_i(line_e), .pel_o(pel), .target_o(target),
    .intr_o(intr), .halt_o(halt), .target_hit_o(hit)
  );

  // {read, addr[2:0], data[7:0]}; for reads data is the expected value
  localparam logic [11:0] VEC [14] = '{
    {1'b0, 3'd3, 8'hFF}, {1'b1, 3'd3, 8'h8F},
    {1'b0, 3'd3, 8'h75}, {1'b1, 3'd3, 8'h05},
    {1'b0, 3'd4, 8'hA5}, {1'b0, 3'd5, 8'hFF},
    {1'b1, 3'd4, 8'hA5}, {1'b1, 3'd5, 8'h3F},
    {1'b0, 3'd6, 8'h34}, {1'b0, 3'd7, 8'h12},
    {1'b1, 3'd6, 8'h34}, {1'b1, 3'd7, 8'h12},
    {1'b0, 3'd6, 8'h56}, {1'b1, 3'd6, 8'h34}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    decode = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic wr_target(input logic [15:0] v);
    wr_reg(3'd6, v[7:0]);
    wr_reg(3'd7, v[15:8]);
  endtask

  task automatic rd_target(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd_reg(3'd6, lo);
    rd_reg(3'd7, hi);
    v = {hi, lo};
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  // line strobe; returns the hit pulse seen in the following cycle
  task automatic line(output logic h);
    @(negedge clk); line_e = 1'b1;
    @(negedge clk); line_e = 1'b0;
    h = hit;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] t;
    logic        h;

    repeat (2) @(negedge clk);
    chk("R1 intr", {15'd0, intr}, 16'd0);
    chk("R1 halt", {15'd0, halt}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    rd_reg(3'd2, b); chk("R1 status", {8'd0, b}, 16'h00);
    rd_reg(3'd3, b); chk("R1 enable", {8'd0, b}, 16'h00);
    rd_reg(3'd4, b); chk("R1 pel lo", {8'd0, b}, 16'h00);
    rd_reg(3'd5, b); chk("R1 pel hi", {8'd0, b}, 16'h00);
    rd_target(t);    chk("R1 target", t, 16'hFFFF);

    // register table: R2 addr 3, R3 addr 4/5, R4 addr 6/7
    for (int i = 0; i < 14; i++) begin
      if (VEC[i][11]) begin
        rd_reg(VEC[i][10:8], b);
        case (VEC[i][10:8])
          3'd3:       chk("R2 enable layout", {8'd0, b}, {8'd0, VEC[i][7:0]});
          3'd4, 3'd5: chk("R3 pel bytes", {8'd0, b}, {8'd0, VEC[i][7:0]});
          default:    chk("R4 target bytes", {8'd0, b}, {8'd0, VEC[i][7:0]});
        endcase
      end else begin
        wr_reg(VEC[i][10:8], VEC[i][7:0]);
      end
    end
    chk("R3 pel_o", {2'b0, pel}, 16'h3FA5);

    // R4: zero update discarded
    wr_target(16'h0000);
    rd_target(t); chk("R4 zero ignored", t, 16'h1234);

    // R5 R6: status sticky, enable gating
    do_reset();
    @(negedge clk); rdy_e = 1'b1; @(negedge clk); rdy_e = 1'b0;
    rd_reg(3'd2, b); chk("R5 rdy status", {8'd0, b}, 16'h02);
    chk("R6 masked", {15'd0, intr}, 16'd0);
    wr_reg(3'd3, 8'h02);
    chk("R6 enabled", {15'd0, intr}, 16'd1);
    wr_reg(3'd3, 8'h00);
    chk("R6 withdrawn", {15'd0, intr}, 16'd0);
    rd_reg(3'd2, b); chk("R5 kept after mask", {8'd0, b}, 16'h02);

    // R10 R11: coding job with overflow, target 3
    do_reset();
    wr_target(16'd3);
    wr_reg(3'd3, 8'h08);
    decode = 1'b0;
    pulse_start();
    @(negedge clk); ovf_e = 1'b1; @(negedge clk); ovf_e = 1'b0;
    chk("R6 R10 ovf intr via en3", {15'd0, intr}, 16'd1);
    line(h); chk("R10 line1 counts on", {15'd0, h}, 16'd0);
    line(h); chk("R11 line2", {15'd0, h}, 16'd0);
    line(h); chk("R11 line3 hit", {15'd0, h}, 16'd1);
    @(negedge clk);
    chk("R11 hit one cycle", {15'd0, hit}, 16'd0);
    line(h); chk("R11 closed no hit", {15'd0, h}, 16'd0);
    rd_reg(3'd2, b); chk("R5 R11 status", {8'd0, b}, 16'h11);

    // R7 R8: decode halt, target 5
    do_reset();
    wr_target(16'd5);
    wr_reg(3'd3, 8'h85);
    decode = 1'b1;
    pulse_start();
    line(h); line(h);
    @(negedge clk); mrk_e = 1'b1; @(negedge clk); mrk_e = 1'b0;
    chk("R8 halt set", {15'd0, halt}, 16'd1);
    chk("R6 marker intr", {15'd0, intr}, 16'd1);
    line(h); line(h);
    chk("R8 halted still", {15'd0, halt}, 16'd1);
    wr_reg(3'd3, 8'h81);
    chk("R6 marker masked", {15'd0, intr}, 16'd0);
    @(negedge clk); stop_e = 1'b1; @(negedge clk); stop_e = 1'b0;
    chk("R7 stop intr while halted", {15'd0, intr}, 16'd1);
    chk("R7 still halted", {15'd0, halt}, 16'd1);
    wr_reg(3'd3, 8'h01);
    chk("R8 halt cleared", {15'd0, halt}, 16'd0);
    line(h); chk("R8 line3", {15'd0, h}, 16'd0);
    line(h); chk("R8 line4", {15'd0, h}, 16'd0);
    line(h); chk("R8 line5 hit", {15'd0, h}, 16'd1);

    // R9: no halt while coding, no halt with bit clear
    do_reset();
    wr_reg(3'd3, 8'h80);
    decode = 1'b0;
    pulse_start();
    @(negedge clk); mrk_e = 1'b1; @(negedge clk); mrk_e = 1'b0;
    chk("R9 coding no halt", {15'd0, halt}, 16'd0);
    wr_reg(3'd3, 8'h00);
    decode = 1'b1;
    pulse_start();
    @(negedge clk); mrk_e = 1'b1; @(negedge clk); mrk_e = 1'b0;
    chk("R9 bit clear no halt", {15'd0, halt}, 16'd0);

    // R12: started at max
    do_reset();
    pulse_start();
    wr_target(16'd2);
    rd_target(t); chk("R12 first rewrite", t, 16'd2);
    wr_target(16'd4);
    rd_target(t); chk("R12 second ignored", t, 16'd2);
    wr_target(16'hFFFF);
    wr_target(16'd4);
    rd_target(t); chk("R12 max then value", t, 16'd4);
    line(h); line(h); line(h);
    chk("R12 line3 no hit", {15'd0, h}, 16'd0);
    line(h); chk("R12 hit at new target", {15'd0, h}, 16'd1);

    // R12: started below max
    do_reset();
    wr_target(16'd10);
    pulse_start();
    wr_target(16'd3);
    rd_target(t); chk("R12 direct ignored", t, 16'd10);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule